// File: doc/BRIEF.md
# Sharing-Biased Replacement Selector for a Last-Level Cache

This block holds the replacement state of one set-associative last-level cache and chooses which way to evict. For each set it keeps a true-LRU ordering of the ways. For each line it keeps a flag that says the line arrived through a remote cache-to-cache coherence transfer, and a bit that says whether the line's home memory is local or remote. For each set it keeps two skip counters, one for each kind of home. Lines that were costly to bring in can then outlive a few eviction attempts before they are finally replaced.

The cache controller sends one operation per cycle on a single valid-qualified port: a hit, a fill, an invalidation or a victim request. A victim request returns the chosen way one cycle later. A separate miss port reports every miss and says whether a remote cache served it. From those reports an adaptive unit turns the biasing on or off with hysteresis, once per fixed window of misses. While biasing is off, the selector is a plain LRU.

Top module: `llc_bias_repl`

## Requirements
- R1: After reset, bias_on and vic_valid are 0, every shared flag is 0, both counters of every set are 0, and in every set way 0 is most recently used and way WAYS-1 is least recently used.
- R2: op_kind is 2'd0 for a hit, 2'd1 for a fill, 2'd2 for an invalidation and 2'd3 for a victim request. A hit or a fill on (op_set, op_way) makes that way the most recently used way of the set. The other ways keep their relative order.
- R3: A victim request raises vic_valid for exactly the next cycle, with the chosen way on vic_way. vic_valid is 0 in every other cycle.
- R4: While bias_on is 0, the victim is the least recently used way. Shared flags are ignored and the counters are left unchanged.
- R5: While bias_on is 1, candidates are examined from least to most recently used. A candidate whose shared flag is 1 is skipped while the counter for its home kind is below that kind's threshold, and each skip adds 1 to that counter. A candidate whose shared flag is 0 is chosen.
- R6: A shared candidate whose home counter has reached its threshold (LOC_THR for a local home, REM_THR for a remote home) is chosen, and that counter is reset to 0.
- R7: If every candidate is skipped, the least recently used way is chosen anyway, and the counters keep the increments from that request.
- R8: A fill writes op_shared into the line's shared flag and op_home_rem into its home bit (1 means remote home). An invalidation clears the shared flag and leaves the LRU order unchanged.
- R9: Misses are counted in windows of WINDOW misses. When a window completes, bias_on becomes 1 if remote×2 ≥ total, becomes 0 if remote×10 ≤ total, and otherwise keeps its value. Both counts then clear. bias_on changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 2 | 0 hit, 1 fill, 2 invalidate, 3 victim request |
| op_set | input | $clog2(SETS) | Set addressed by the operation |
| op_way | input | $clog2(WAYS) | Way for a hit, fill or invalidate |
| op_shared | input | 1 | Fill arrived through a remote cache-to-cache transfer |
| op_home_rem | input | 1 | Filled line has a remote home |
| miss_valid | input | 1 | One cache miss is reported this cycle |
| miss_remote | input | 1 | That miss was served by a remote cache |
| vic_valid | output | 1 | Victim result valid |
| vic_way | output | $clog2(WAYS) | Way to evict |
| bias_on | output | 1 | Sharing bias currently enabled |

## Verification
The watermark logic is driven with whole windows whose remote counts sit just below, on and above each watermark, given in an order that steps across the hysteresis band in both directions. This separates a correct hold from a wrongly computed comparison. Victim selection is first tried with directed line mixes: a lone local-home shared line, a lone remote-home shared line, and a set that is fully shared with mixed homes. These show the two thresholds, the counter reset and the fallback to the oldest way. A long deterministic mix of hits, fills, invalidations and victim requests over all sets then runs with the bias toggled between phases. This sweeps the LRU orderings and counter states against an ordered-list model written from the requirements.

// File: rtl/llc_bias_pkg.sv
package llc_bias_pkg;

  typedef enum logic [1:0] {
    OP_HIT    = 2'd0,
    OP_FILL   = 2'd1,
    OP_INVAL  = 2'd2,
    OP_VICTIM = 2'd3
  } op_kind_e;

  // remote fraction at or above one half
  function automatic logic frac_at_high(input logic [31:0] rem, input logic [31:0] tot);
    return (rem * 32'd2) >= tot;
  endfunction

  // remote fraction at or below one tenth
  function automatic logic frac_at_low(input logic [31:0] rem, input logic [31:0] tot);
    return (rem * 32'd10) <= tot;
  endfunction

endpackage

// File: rtl/llc_lru_state.sv
module llc_lru_state #(
  parameter int WAYS = 8,
  parameter int SETS = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        touch_en,
  input  logic [SET_W-1:0]            touch_set,
  input  logic [WAY_W-1:0]            touch_way,
  input  logic [SET_W-1:0]            rd_set,
  output logic [WAYS-1:0][WAY_W-1:0]  rd_age,
  output logic [WAYS-1:0]             lru_vec,
  output logic [WAY_W-1:0]            lru_way
);
  typedef logic [WAYS-1:0][WAY_W-1:0] age_row_t;

  age_row_t age_q [SETS];

  // age 0 is most recent; younger ways than the touched one age by one
  function automatic age_row_t touch_ages(input age_row_t a, input logic [WAY_W-1:0] w);
    age_row_t r;
    for (int i = 0; i < WAYS; i++)
      r[i] = (a[i] < a[w]) ? a[i] + WAY_W'(1) : a[i];
    r[w] = '0;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      age_q[touch_set] <= touch_ages(age_q[touch_set], touch_way);
    end
  end

  assign rd_age = age_q[rd_set];

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      lru_vec[w] = (rd_age[w] == WAY_W'(WAYS - 1));
      if (lru_vec[w]) lru_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/llc_victim_pick.sv
module llc_victim_pick #(
  parameter int WAYS    = 8,
  parameter int LOC_THR = 2,
  parameter int REM_THR = 4,
  parameter int CNT_W   = 3,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic                        bias_on,
  input  logic [WAYS-1:0][WAY_W-1:0]  ages,
  input  logic [WAYS-1:0]             shared,
  input  logic [WAYS-1:0]             home_rem,
  input  logic [CNT_W-1:0]            cnt_loc,
  input  logic [CNT_W-1:0]            cnt_rem,
  output logic [WAY_W-1:0]            pick_way,
  output logic [CNT_W-1:0]            cnt_loc_n,
  output logic [CNT_W-1:0]            cnt_rem_n
);
  function automatic logic [WAY_W-1:0] way_at_age(input logic [WAYS-1:0][WAY_W-1:0] a,
                                                  input int rank);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = 0; w < WAYS; w++)
      if (a[w] == WAY_W'(rank)) r = WAY_W'(w);
    return r;
  endfunction

  logic             found;
  logic [WAY_W-1:0] cand;
  logic             below;

  always_comb begin
    cnt_loc_n = cnt_loc;
    cnt_rem_n = cnt_rem;
    found     = 1'b0;
    pick_way  = way_at_age(ages, WAYS - 1);   // fallback: oldest
    cand      = '0;
    below     = 1'b0;
    for (int r = WAYS - 1; r >= 0; r--) begin
      if (!found) begin
        cand  = way_at_age(ages, r);
        below = home_rem[cand] ? (cnt_rem_n < CNT_W'(REM_THR))
                               : (cnt_loc_n < CNT_W'(LOC_THR));
        if (bias_on && shared[cand] && below) begin
          if (home_rem[cand]) cnt_rem_n = cnt_rem_n + CNT_W'(1);
          else                cnt_loc_n = cnt_loc_n + CNT_W'(1);
        end else begin
          found    = 1'b1;
          pick_way = cand;
          if (bias_on && shared[cand]) begin
            if (home_rem[cand]) cnt_rem_n = '0;
            else                cnt_loc_n = '0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/llc_bias_ctrl.sv
module llc_bias_ctrl
  import llc_bias_pkg::*;
#(
  parameter int WINDOW = 1024,
  localparam int TOT_W = $clog2(WINDOW + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic miss_valid,
  input  logic miss_remote,
  output logic win_end,
  output logic bias_on
);
  logic [TOT_W-1:0] tot_q, rem_q, tot_n, rem_n;

  assign tot_n   = tot_q + TOT_W'(1);
  assign rem_n   = rem_q + TOT_W'(miss_remote);
  assign win_end = miss_valid && (tot_n == TOT_W'(WINDOW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_q   <= '0;
      rem_q   <= '0;
      bias_on <= 1'b0;
    end else if (win_end) begin
      tot_q <= '0;
      rem_q <= '0;
      if (frac_at_high(32'(rem_n), 32'(WINDOW)))     bias_on <= 1'b1;
      else if (frac_at_low(32'(rem_n), 32'(WINDOW))) bias_on <= 1'b0;
    end else if (miss_valid) begin
      tot_q <= tot_n;
      rem_q <= rem_n;
    end
  end

endmodule

// File: rtl/llc_bias_repl.sv
module llc_bias_repl
  import llc_bias_pkg::*;
#(
  parameter int WAYS    = 8,
  parameter int SETS    = 16,
  parameter int LOC_THR = 2,
  parameter int REM_THR = 4,
  parameter int WINDOW  = 1024,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int SET_W  = $clog2(SETS),
  localparam int MAX_T  = (LOC_THR > REM_THR) ? LOC_THR : REM_THR,
  localparam int CNT_W  = $clog2(MAX_T + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [1:0]       op_kind,
  input  logic [SET_W-1:0] op_set,
  input  logic [WAY_W-1:0] op_way,
  input  logic             op_shared,
  input  logic             op_home_rem,
  input  logic             miss_valid,
  input  logic             miss_remote,
  output logic             vic_valid,
  output logic [WAY_W-1:0] vic_way,
  output logic             bias_on
);
  op_kind_e kind;
  logic     do_touch, do_fill, do_inval, do_victim;

  assign kind      = op_kind_e'(op_kind);
  assign do_fill   = op_valid && (kind == OP_FILL);
  assign do_inval  = op_valid && (kind == OP_INVAL);
  assign do_victim = op_valid && (kind == OP_VICTIM);
  assign do_touch  = op_valid && ((kind == OP_HIT) || (kind == OP_FILL));

  logic [WAYS-1:0]  shared_q   [SETS];
  logic [WAYS-1:0]  home_q     [SETS];
  logic [CNT_W-1:0] cnt_loc_q  [SETS];
  logic [CNT_W-1:0] cnt_rem_q  [SETS];

  logic [WAYS-1:0][WAY_W-1:0] rd_age;
  logic [WAYS-1:0]            lru_vec;
  logic [WAY_W-1:0]           lru_way;
  logic [WAY_W-1:0]           pick_way;
  logic [CNT_W-1:0]           pick_cl_n, pick_cr_n;
  logic                       win_end;

  llc_lru_state #(.WAYS(WAYS), .SETS(SETS)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .touch_en(do_touch), .touch_set(op_set), .touch_way(op_way),
    .rd_set(op_set), .rd_age(rd_age), .lru_vec(lru_vec), .lru_way(lru_way)
  );

  llc_victim_pick #(.WAYS(WAYS), .LOC_THR(LOC_THR), .REM_THR(REM_THR), .CNT_W(CNT_W)) u_pick (
    .bias_on(bias_on), .ages(rd_age),
    .shared(shared_q[op_set]), .home_rem(home_q[op_set]),
    .cnt_loc(cnt_loc_q[op_set]), .cnt_rem(cnt_rem_q[op_set]),
    .pick_way(pick_way), .cnt_loc_n(pick_cl_n), .cnt_rem_n(pick_cr_n)
  );

  llc_bias_ctrl #(.WINDOW(WINDOW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_remote(miss_remote),
    .win_end(win_end), .bias_on(bias_on)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        shared_q[s]  <= '0;
        home_q[s]    <= '0;
        cnt_loc_q[s] <= '0;
        cnt_rem_q[s] <= '0;
      end
    end else begin
      if (do_fill) begin
        shared_q[op_set][op_way] <= op_shared;
        home_q[op_set][op_way]   <= op_home_rem;
      end
      if (do_inval) shared_q[op_set][op_way] <= 1'b0;
      if (do_victim) begin
        cnt_loc_q[op_set] <= pick_cl_n;
        cnt_rem_q[op_set] <= pick_cr_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vic_valid <= 1'b0;
      vic_way   <= '0;
    end else begin
      vic_valid <= do_victim;
      if (do_victim) vic_way <= pick_way;
    end
  end

endmodule

// File: rtl/llc_bias_chk.sv
module llc_bias_chk #(
  parameter int WAYS    = 8,
  parameter int LOC_THR = 2,
  parameter int REM_THR = 4,
  parameter int CNT_W   = 3,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [1:0]       op_kind,
  input logic             vic_valid,
  input logic [WAY_W-1:0] vic_way,
  input logic             bias_on,
  input logic             win_end,
  input logic [WAY_W-1:0] lru_way,
  input logic [WAYS-1:0]  lru_vec,
  input logic [CNT_W-1:0] pick_cl_n,
  input logic [CNT_W-1:0] pick_cr_n
);
  logic vreq;
  assign vreq = op_valid && (op_kind == 2'd3);

  p_vic_follows_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vreq |=> vic_valid);

  p_vic_only_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !vreq |=> !vic_valid);

  p_plain_lru_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vreq && !bias_on) |=> (vic_way == $past(lru_way)));

  p_single_oldest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lru_vec) == 1);

  p_cnt_within_thr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vreq |-> ((pick_cl_n <= CNT_W'(LOC_THR)) && (pick_cr_n <= CNT_W'(REM_THR))));

  p_bias_moves_at_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_on != $past(bias_on)) |-> $past(win_end));

endmodule

bind llc_bias_repl llc_bias_chk #(
  .WAYS(WAYS), .LOC_THR(LOC_THR), .REM_THR(REM_THR), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
  .vic_valid(vic_valid), .vic_way(vic_way), .bias_on(bias_on), .win_end(win_end),
  .lru_way(lru_way), .lru_vec(lru_vec), .pick_cl_n(pick_cl_n), .pick_cr_n(pick_cr_n)
);

// File: tb/sim_llc_bias_repl.sv
module sim_llc_bias_repl;
  localparam int NW = 4, NS = 4, LT = 2, RT = 3, WIN = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 0, op_shared = 0, op_home_rem = 0, miss_valid = 0, miss_remote = 0;
  logic [1:0] op_kind = 0, op_set = 0, op_way = 0;
  logic vic_valid, bias_on;
  logic [1:0] vic_way;

  always #10 clk = ~clk;   // 50 MHz

  llc_bias_repl #(.WAYS(NW), .SETS(NS), .LOC_THR(LT), .REM_THR(RT), .WINDOW(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .op_set(op_set),
    .op_way(op_way), .op_shared(op_shared), .op_home_rem(op_home_rem),
    .miss_valid(miss_valid), .miss_remote(miss_remote),
    .vic_valid(vic_valid), .vic_way(vic_way), .bias_on(bias_on)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model: ordered list, index 0 = most recent
  int ord [NS][NW];
  bit sh [NS][NW], hr [NS][NW];
  int cl [NS], cr [NS];
  bit m_bias = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void m_touch(input int s, input int w);
    int p = 0;
    for (int i = 0; i < NW; i++) if (ord[s][i] == w) p = i;
    for (int i = p; i > 0; i--) ord[s][i] = ord[s][i-1];
    ord[s][0] = w;
  endfunction

  function automatic int m_victim(input int s);
    for (int i = NW - 1; i >= 0; i--) begin
      int w = ord[s][i];
      if (!m_bias || !sh[s][w]) return w;
      if (hr[s][w]) begin
        if (cr[s] < RT) begin cr[s]++; continue; end
        cr[s] = 0; return w;
      end else begin
        if (cl[s] < LT) begin cl[s]++; continue; end
        cl[s] = 0; return w;
      end
    end
    return ord[s][NW-1];
  endfunction

  task automatic do_op(input int k, input int s, input int w, input bit shv, input bit hrv);
    @(negedge clk);
    op_valid = 1; op_kind = 2'(k); op_set = 2'(s); op_way = 2'(w);
    op_shared = shv; op_home_rem = hrv;
    @(negedge clk);
    op_valid = 0;
    if (k == 0 || k == 1) m_touch(s, w);
    if (k == 1) begin sh[s][w] = shv; hr[s][w] = hrv; end
    if (k == 2) sh[s][w] = 0;
  endtask

  task automatic do_victim(input int s, input string tag);
    int exp;
    do_op(3, s, 0, 0, 0);
    exp = m_victim(s);
    check(vic_valid === 1'b1, {tag, " valid"}, int'(vic_valid), 1);
    check(int'(vic_way) == exp, tag, int'(vic_way), exp);
  endtask

  task automatic window(input int nrem, input bit check_it);
    real f;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk); miss_valid = 1; miss_remote = (i < nrem);
      @(negedge clk); miss_valid = 0;
      if (check_it && i == WIN - 2)
        check(bias_on == m_bias, "R9 hold inside window", int'(bias_on), int'(m_bias));
    end
    f = real'(nrem) / real'(WIN);
    if (f >= 0.5) m_bias = 1;
    else if (f <= 0.1) m_bias = 0;
    if (check_it) check(bias_on == m_bias, "R9 window end", int'(bias_on), int'(m_bias));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed = 7;
    for (int s = 0; s < NS; s++) begin
      cl[s] = 0; cr[s] = 0;
      for (int w = 0; w < NW; w++) begin ord[s][w] = w; sh[s][w] = 0; hr[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(bias_on == 0, "R1 bias after reset", int'(bias_on), 0);
    check(vic_valid == 0, "R1 vic_valid after reset", int'(vic_valid), 0);
    do_victim(0, "R1 fresh set oldest is last way");
    @(negedge clk);
    check(vic_valid == 0, "R3 one-cycle pulse", int'(vic_valid), 0);

    // R9: watermark crossings in both directions
    window(9, 1); window(10, 1); window(3, 1); window(2, 1);
    window(12, 1); window(5, 1); window(0, 1); window(1, 1); window(20, 1);

    // R5 R6: lone local-home shared line in set 2 (bias on)
    for (int w = 0; w < NW; w++) do_op(1, 2, w, (w == 0), 0);
    for (int i = 0; i < 4; i++) do_victim(2, "R5 R6 local threshold");
    // R5 R6: lone remote-home shared line in set 3
    for (int w = 0; w < NW; w++) do_op(1, 3, w, (w == 0), 1);
    for (int i = 0; i < 5; i++) do_victim(3, "R5 R6 remote threshold");
    // R8: invalidation clears the flag, so the oldest line goes at once
    do_op(2, 3, 0, 0, 0);
    do_victim(3, "R8 invalidated line evicted");
    // R7: fully shared set with mixed homes
    for (int w = 0; w < NW; w++) do_op(1, 1, w, 1, (w < 2));
    for (int i = 0; i < 4; i++) do_victim(1, "R7 all skipped fallback");
    // R4: bias off ignores flags and leaves counters untouched
    window(0, 1);
    for (int i = 0; i < 3; i++) begin
      do_victim(1, "R4 plain LRU");
      do_op(0, 1, i, 0, 0);
    end
    window(20, 1);
    do_victim(1, "R4 counters kept across bias off");

    // R2: every touch order of one set, bias off
    window(0, 0);
    for (int a = 0; a < NW; a++)
      for (int b = 0; b < NW; b++) begin
        do_op(0, 0, a, 0, 0);
        do_op(0, 0, b, 0, 0);
        do_victim(0, "R2 LRU order after hits");
      end

    // mixed deterministic sweep, bias toggled per phase
    for (int ph = 0; ph < 6; ph++) begin
      window((ph % 2 == 0) ? 15 : 1, 1);
      for (int n = 0; n < 400; n++) begin
        int r, k, s, w;
        seed = seed * 1103515245 + 12345;
        r = (seed >>> 8) & 32'h7fff;
        s = r % NS; w = (r / 4) % NW; k = (r / 16) % 8;
        if (k < 3)       do_op(0, s, w, 0, 0);
        else if (k < 5)  do_op(1, s, w, (r / 128) % 2, (r / 256) % 2);
        else if (k == 5) do_op(2, s, w, 0, 0);
        else             do_victim(s, "R5 R6 R7 R8 mixed sweep");
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule